// File: doc/BRIEF.md
# Main Clock Source Switch

This block picks the chip's main clock from four candidate sources and hands the clock over between them without glitches. Software writes a 2-bit source choice into a shadow register. That choice stays dormant until software arms it through a separate one-bit commit register, by writing 0 and then 1. At that rising commit the block captures the shadow value and starts a handover. The handover waits until both the current source and the chosen source report that they are running. It then turns off the current source's gate on that source's falling edge. Only after the off state has crossed through synchronizers does it turn on the new source's gate, on the new source's falling edge.

A read-only status bit stays high from the commit until the new source drives the output. If software commits again during a handover, the request is kept and carried out after the running handover finishes. The handover in progress is never abandoned.

Top module: `mainclk_switch`

## Requirements
- R1: Source code 0 routes the on-chip RC clock (`src_clk[0]`), code 1 the PLL input clock (`src_clk[1]`), code 2 the watchdog oscillator (`src_clk[2]`) and code 3 the PLL output clock (`src_clk[3]`) to `clk_out` once the handover completes.
- R2: Writing the source register (word address 0, bits 1:0) alone never changes the source driving `clk_out`.
- R3: A handover starts only when the commit register (word address 1, bit 0) holds 0 and then receives a write with bit 0 set. A write of 1 while it already holds 1 has no effect.
- R4: A handover does not switch until `src_running` is high for both the current and the chosen source. While it waits, the old source keeps driving `clk_out`.
- R5: After reset the source register reads 0, the commit register reads 0, the status bit reads 0 and `clk_out` follows source 0.
- R6: Bits 31:2 of the source register, bits 31:1 of the commit and status registers, and every read of word address 3 return zero. Writes to reserved bits have no lasting effect.
- R7: At most one source gate is open at any time. `clk_out` shows no high or low pulse shorter than the narrowest half period of the sources involved.
- R8: The status bit (word address 2, bit 0) is 1 from a commit until the new source drives `clk_out`, and 0 otherwise.
- R9: A commit that arrives while a handover is pending is latched and applied after the current handover completes. It uses the source value that was in the shadow register at the moment of that commit.
- R10: A read of the source register returns the value last written, not the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_clk | input | 4 | Candidate clock sources, indexed by source code |
| src_running | input | 4 | Per-source running indication, asynchronous |
| clk_out | output | 1 | Gated main clock |

## Verification
The bench identifies the active source by counting `clk_out` edges over a fixed window against four distinct source periods. A design that applied the shadow value on a plain write, or on a repeated 1 commit, would show the new source's frequency too early. A handover that ignored the running flag would switch onto a stopped source and the count would fall off. A dropped queued commit would leave the intermediate source active. A monitor measures every `clk_out` level duration, so a gate that opened before the other closed shows up as a runt pulse.

// File: rtl/mainclk_pkg.sv
`timescale 1ns/1ps
package mainclk_pkg;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int ADDR_W = 2;
  localparam int DW     = 32;

  localparam logic [ADDR_W-1:0] A_SEL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT,
    HS_DROP,
    HS_RAISE
  } hs_state_e;
endpackage

// File: rtl/mainclk_sync.sv
`timescale 1ns/1ps
module mainclk_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mainclk_lane.sv
`timescale 1ns/1ps
module mainclk_lane (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  input  logic others_on,
  output logic gate_on
);
  logic req_s;
  logic oth_s;

  mainclk_sync #(.W(1)) u_req (.clk(src_clk), .rst(rst), .d(req),       .q(req_s));
  mainclk_sync #(.W(1)) u_oth (.clk(src_clk), .rst(rst), .d(others_on), .q(oth_s));

  // gate changes only while the source is low
  always_ff @(negedge src_clk) begin
    if (rst) gate_on <= 1'b0;
    else     gate_on <= req_s & ~oth_s;
  end
endmodule

// File: rtl/mainclk_regs.sv
`timescale 1ns/1ps
module mainclk_regs
  import mainclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              busy,
  output logic [DW-1:0]     bus_rdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic              commit_q
);
  logic cmt_bit_q;
  logic wr_cmt;

  assign wr_cmt = bus_wr && (bus_addr == A_CMT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      cmt_bit_q <= 1'b0;
      commit_q  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      commit_q <= wr_cmt && bus_wdata[0] && !cmt_bit_q;
      if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_cmt) cmt_bit_q <= bus_wdata[0];
      if (bus_rd) begin
        bus_rdata <= '0;
        case (bus_addr)
          A_SEL:   bus_rdata[SEL_W-1:0] <= sel_q;
          A_CMT:   bus_rdata[0]         <= cmt_bit_q;
          A_STAT:  bus_rdata[0]         <= busy;
          default: bus_rdata            <= '0;
        endcase
      end
    end
  end

  AST_REPEAT_ONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_cmt && cmt_bit_q) |=> !commit_q); // R3
endmodule

// File: rtl/mainclk_ctrl.sv
`timescale 1ns/1ps
module mainclk_ctrl
  import mainclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  run_async,
  input  logic [NSRC-1:0]  gate_async,
  output logic [NSRC-1:0]  req_q,
  output logic             busy_q
);
  hs_state_e        state_q;
  logic [SEL_W-1:0] cur_q, tgt_q, pend_sel_q;
  logic             pend_q;
  logic [NSRC-1:0]  run_s, gate_s;

  mainclk_sync #(.W(NSRC)) u_run  (.clk(clk), .rst(rst), .d(run_async),  .q(run_s));
  mainclk_sync #(.W(NSRC)) u_gate (.clk(clk), .rst(rst), .d(gate_async), .q(gate_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= HS_IDLE;
      cur_q      <= '0;
      tgt_q      <= '0;
      pend_q     <= 1'b0;
      pend_sel_q <= '0;
      req_q      <= NSRC'(1);
      busy_q     <= 1'b0;
    end else begin
      busy_q <= (state_q != HS_IDLE) || pend_q || commit;
      case (state_q)
        HS_IDLE: if (pend_q) begin
          tgt_q   <= pend_sel_q;
          pend_q  <= 1'b0;
          state_q <= HS_WAIT;
        end
        HS_WAIT: begin
          if (tgt_q == cur_q) state_q <= HS_IDLE;
          else if (run_s[tgt_q] && run_s[cur_q]) begin
            req_q[cur_q] <= 1'b0;
            state_q      <= HS_DROP;
          end
        end
        HS_DROP: if (!gate_s[cur_q]) begin
          req_q[tgt_q] <= 1'b1;
          state_q      <= HS_RAISE;
        end
        HS_RAISE: if (gate_s[tgt_q]) begin
          cur_q   <= tgt_q;
          state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
      if (commit) begin
        pend_q     <= 1'b1;
        pend_sel_q <= sel;
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst) $onehot0(req_q)); // R7
  AST_ONE_GATE: assert property (@(posedge clk) disable iff (rst) $onehot0(gate_s)); // R7
  AST_HOLD_CUR: assert property (@(posedge clk) disable iff (rst)
    (state_q != HS_RAISE) |=> $stable(cur_q)); // R2
  AST_RUN_BEFORE_DROP: assert property (@(posedge clk) disable iff (rst)
    (state_q == HS_DROP && $past(state_q) == HS_WAIT) |-> $past(run_s[tgt_q] && run_s[cur_q])); // R4
  AST_QUEUE_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (commit && state_q != HS_IDLE) |=> pend_q); // R9
  AST_BUSY_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    (pend_q || state_q == HS_DROP) |=> busy_q); // R8
endmodule

// File: rtl/mainclk_switch.sv
`timescale 1ns/1ps
module mainclk_switch
  import mainclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   src_clk,
  input  logic [NSRC-1:0]   src_running,
  output logic              clk_out
);
  logic [SEL_W-1:0] sel_q;
  logic             commit_q;
  logic             busy_q;
  logic [NSRC-1:0]  req_q;
  logic [NSRC-1:0]  gate_on;

  mainclk_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy_q), .bus_rdata(bus_rdata),
    .sel_q(sel_q), .commit_q(commit_q)
  );

  mainclk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .commit(commit_q), .sel(sel_q),
    .run_async(src_running), .gate_async(gate_on), .req_q(req_q), .busy_q(busy_q)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    logic [NSRC-1:0] mask;
    always_comb begin
      mask    = gate_on;
      mask[i] = 1'b0;
    end
    mainclk_lane u_lane (
      .src_clk(src_clk[i]), .rst(rst), .req(req_q[i]),
      .others_on(|mask), .gate_on(gate_on[i])
    );
  end

  assign clk_out = |(src_clk & gate_on);
endmodule

// File: tb/sim_mainclk_switch.sv
`timescale 1ns/1ps
module sim_mainclk_switch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_clk = '0;
  logic [3:0]  src_running = 4'b1111;
  logic        clk_out;

  int checks = 0, errors = 0;
  int edge_cnt = 0, runts = 0;
  bit mon_on = 0;
  realtime last_t = 0;

  localparam real WIN = 660.0;
  localparam logic [1:0] SEQ [5] = '{2'd3, 2'd1, 2'd2, 2'd0, 2'd2};

  always #2 clk = ~clk;
  always #5  src_clk[0] = ~src_clk[0];
  always #7  src_clk[1] = ~src_clk[1];
  always #11 src_clk[2] = ~src_clk[2];
  always #3  src_clk[3] = ~src_clk[3];

  mainclk_switch u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_clk(src_clk),
    .src_running(src_running), .clk_out(clk_out)
  );

  always @(posedge clk_out) edge_cnt++;
  always @(clk_out) begin
    if (mon_on && ($realtime - last_t) < 2.5) runts++;
    last_t = $realtime;
  end

  function automatic real period(input int s);
    case (s)
      0: return 10.0;
      1: return 14.0;
      2: return 22.0;
      default: return 6.0;
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic commit();
    wr(2'd1, 32'd0);
    wr(2'd1, 32'd1);
  endtask

  task automatic check_src(input string req, input int s);
    int a, n, e;
    a = edge_cnt;
    #(WIN);
    n = edge_cnt - a;
    e = int'(WIN / period(s));
    checks++;
    if (n < e - 2 || n > e + 2) begin
      errors++;
      $display("FAIL %s: actual %0d edges expected %0d (source %0d)", req, n, e, s);
    end
    @(negedge clk);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    d = 1;
    for (int i = 0; i < 400 && d[0]; i++) rd(2'd2, d);
    check(req, d, 0);
  endtask

  initial begin
    logic [31:0] d;
    repeat (20) @(negedge clk);
    rst = 0;
    repeat (30) @(negedge clk);
    mon_on = 1;

    // R5 reset state
    rd(2'd0, d); check("R5 sel", d, 0);
    rd(2'd1, d); check("R5 commit", d, 0);
    rd(2'd2, d); check("R5 status", d, 0);
    check_src("R5 clk", 0);

    // R6 reserved bits
    wr(2'd0, 32'hFFFF_FFFE); rd(2'd0, d); check("R6 sel reserved", d, 2);
    wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, d); check("R6 commit reserved", d, 0);
    rd(2'd3, d); check("R6 unmapped", d, 0);

    // R2 / R10 select alone has no effect, read returns shadow
    wr(2'd0, 32'd3);
    repeat (50) @(negedge clk);
    rd(2'd0, d); check("R10 shadow", d, 3);
    rd(2'd2, d); check("R2 status", d, 0);
    check_src("R2 clk", 0);

    // R1 table walk
    foreach (SEQ[k]) begin
      wr(2'd0, 32'(SEQ[k]));
      commit();
      wait_idle("R8 done");
      check_src("R1", SEQ[k]);
    end

    // R3 repeated 1 without 0
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd1);
    repeat (50) @(negedge clk);
    rd(2'd2, d); check("R3 status", d, 0);
    rd(2'd1, d); check("R3 commit reads", d, 1);
    check_src("R3 clk", 2);

    // R4 hold off until new source runs
    src_running[1] = 0;
    commit();
    repeat (200) @(negedge clk);
    rd(2'd2, d); check("R8 pending", d, 1);
    check_src("R4 held", 2);
    src_running[1] = 1;
    wait_idle("R4 done");
    check_src("R4 switched", 1);

    // R9 queued commit
    src_running[0] = 0;
    wr(2'd0, 32'd0); commit();
    repeat (20) @(negedge clk);
    wr(2'd0, 32'd3); commit();
    repeat (100) @(negedge clk);
    rd(2'd2, d); check("R9 pending", d, 1);
    check_src("R9 held", 1);
    src_running[0] = 1;
    wait_idle("R9 done");
    check_src("R9 final", 3);
    rd(2'd0, d); check("R10 shadow", d, 3);

    check("R7 runt pulses", runts, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule